// File: doc/BRIEF.md
# Page-Buffered Write Controller with Completion Status

This block is a clocked controller that sits in front of a byte-wide nonvolatile storage model. A host issues byte loads on a synchronous bus made of a select, a read enable, a write enable, an address and a data byte. The controller gathers these loads into a page buffer. The page is fixed by the first load of an operation. When no further load arrives within a set number of cycles, the controller starts a self-timed programming phase. At the end of that phase it copies every buffered byte into an on-chip register array in a single cycle.

While programming is under way, reads do not return stored data. They return two status bits instead. The top data bit is the complement of the last byte loaded, but only when the last loaded address is read. The bit just below it changes value on every read. A host can therefore find out when programming is complete by comparing two successive reads, or by reading back the last byte it wrote. The load window and the programming time are both parameters counted in clock cycles. The array size, page size and data width are parameters too.

Top module: `pgwr_ctrl`

## Requirements
- R1: A byte load is taken only in a cycle where `sel`=1, `wr_en`=1 and `rd_en`=0. A read happens in a cycle where `sel`=1 and `rd_en`=1, whatever `wr_en` is. `rdata_oe` is 1 exactly in read cycles. Outside read cycles `rdata` is all zeros.
- R2: `addr[PAGE_BITS-1:0]` selects the byte within a page and the bits above it select the page. With `PAGE_BITS`=8, any number of loads from 1 to 256 is buffered and committed.
- R3: After a load is accepted, another load to the same page is accepted if it comes 1 to `LOAD_WIN` cycles later, and this restarts the window. If no such load arrives, `busy` rises after the `LOAD_WIN`-th clock edge following the last accepted load.
- R4: While loads are being collected, a load to a page other than the open one is dropped. It does not restart the window, and `page_err` is 1 for the one cycle that follows it.
- R5: While `busy`=1, a read of the last loaded address returns that byte with bit 7 (the top bit) inverted and bits 5..0 unchanged.
- R6: While `busy`=1, bit 6 of the read data is 0 on the first read after programming starts and inverts on each further read.
- R7: `busy` stays 1 for exactly `PROG_CYC` cycles. Write cycles during that time change nothing and do not raise `page_err`.
- R8: Once `busy` falls, reads return the committed bytes unchanged.
- R9: Byte positions not loaded during an operation keep their previous contents when the page is committed.
- R10: Reset clears the whole array to zero and sets `busy`, `page_err` and `rdata_oe` to 0.
- R11: While `busy`=1, a read of any address other than the last loaded one returns zeros except in bit 6.
- R12: While loads are still being collected, reads return the array contents, not the bytes waiting in the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Chip select, active high |
| rd_en | input | 1 | Read/output enable, active high |
| wr_en | input | 1 | Write enable, active high |
| addr | input | ADDR_W | Byte address (page, then offset) |
| wdata | input | DATA_W | Byte to load |
| rdata | output | DATA_W | Read data or programming status |
| rdata_oe | output | 1 | Read data is being driven |
| busy | output | 1 | Programming phase in progress |
| page_err | output | 1 | One-cycle flag for a dropped wrong-page load |

## Verification
Several load patterns are used. There are scattered bytes within one page, a single-byte operation over data already committed, and a full page of 256 loads. Together these separate a correct commit from one that loses bytes, overwrites bytes that were not loaded, or mis-decodes the offset. A load placed exactly at the window limit is compared with one placed one cycle late, which pins down the timeout edge. A wrong-page load in the middle of an operation checks that the load is dropped and that the flag is raised. Sequences of status reads that alternate between the last address and other addresses check the complemented top bit, the zero fill, and the alternating bit 6, whose phase depends on every read made since programming started.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic [1:0] {
      PG_IDLE = 2'd0,
      PG_LOAD = 2'd1,
      PG_PROG = 2'd2
   } pg_state_e;
endpackage

// File: rtl/pgwr_seq.sv
module pgwr_seq
   import pgwr_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int PAGE_BITS = 8,
   parameter int LOAD_WIN  = 5000,
   parameter int PROG_CYC  = 500000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_req,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           wdata,
   output logic                        ld_en,
   output logic                        busy,
   output logic                        commit,
   output logic                        prog_start,
   output logic [ADDR_W-PAGE_BITS-1:0] page_q,
   output logic [ADDR_W-1:0]           last_addr,
   output logic [DATA_W-1:0]           last_data,
   output logic                        page_err
);
   localparam int PG_W = ADDR_W - PAGE_BITS;
   localparam int WC_W = $clog2(LOAD_WIN);
   localparam int PC_W = $clog2(PROG_CYC);

   pg_state_e         st_q;
   logic [WC_W-1:0]   wcnt_q;
   logic [PC_W-1:0]   pcnt_q;
   logic [PG_W-1:0]   in_page;
   logic              win_end;

   assign in_page    = addr[ADDR_W-1:PAGE_BITS];
   assign win_end    = (wcnt_q == WC_W'(LOAD_WIN - 1));
   assign ld_en      = wr_req && ((st_q == PG_IDLE) ||
                                  ((st_q == PG_LOAD) && (in_page == page_q)));
   assign prog_start = (st_q == PG_LOAD) && !ld_en && win_end;
   assign commit     = (st_q == PG_PROG) && (pcnt_q == PC_W'(PROG_CYC - 1));
   assign busy       = (st_q == PG_PROG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= PG_IDLE;
         wcnt_q    <= '0;
         pcnt_q    <= '0;
         page_q    <= '0;
         last_addr <= '0;
         last_data <= '0;
         page_err  <= 1'b0;
      end else begin
         page_err <= 1'b0;
         case (st_q)
            PG_IDLE: begin
               if (wr_req) begin
                  page_q    <= in_page;
                  last_addr <= addr;
                  last_data <= wdata;
                  wcnt_q    <= '0;
                  st_q      <= PG_LOAD;
               end
            end
            PG_LOAD: begin
               if (ld_en) begin
                  last_addr <= addr;
                  last_data <= wdata;
                  wcnt_q    <= '0;
               end else begin
                  if (wr_req) page_err <= 1'b1;
                  if (win_end) begin
                     st_q   <= PG_PROG;
                     pcnt_q <= '0;
                  end else begin
                     wcnt_q <= wcnt_q + 1'b1;
                  end
               end
            end
            PG_PROG: begin
               if (commit) st_q <= PG_IDLE;
               else        pcnt_q <= pcnt_q + 1'b1;
            end
            default: st_q <= PG_IDLE;
         endcase
      end
   end

   // R3
   load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> !busy);

   // R7
   prog_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (pcnt_q == '0));

   // R7
   last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(last_addr) && $stable(last_data)));

   // R4
   err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_err |-> ($past(st_q == PG_LOAD) && !$past(ld_en)));
endmodule

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf #(
   parameter int DATA_W    = 8,
   parameter int PAGE_BITS = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   ld_en,
   input  logic [PAGE_BITS-1:0]                   ld_off,
   input  logic [DATA_W-1:0]                      ld_data,
   input  logic                                   clear,
   output logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0]  pbuf_data,
   output logic [(1<<PAGE_BITS)-1:0]              pbuf_vld
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pbuf_data <= '0;
         pbuf_vld  <= '0;
      end else if (clear) begin
         pbuf_vld <= '0;
      end else if (ld_en) begin
         pbuf_data[ld_off] <= ld_data;
         pbuf_vld[ld_off]  <= 1'b1;
      end
   end

   // R9
   vld_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (pbuf_vld == '0));

   // R2
   load_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !clear) |=> pbuf_vld[$past(ld_off)]);
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
   parameter int ADDR_W      = 17,
   parameter int DATA_W      = 8,
   parameter int PAGE_BITS   = 8,
   parameter bit RESET_ARRAY = 1'b1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   commit,
   input  logic [ADDR_W-PAGE_BITS-1:0]            commit_page,
   input  logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0]  pbuf_data,
   input  logic [(1<<PAGE_BITS)-1:0]              pbuf_vld,
   input  logic [ADDR_W-1:0]                      rd_addr,
   output logic [DATA_W-1:0]                      rd_data
);
   localparam int DEPTH      = 1 << ADDR_W;
   localparam int PAGE_BYTES = 1 << PAGE_BITS;
   localparam int PG_W       = ADDR_W - PAGE_BITS;

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      localparam logic [PG_W-1:0] WPG  = PG_W'(w >> PAGE_BITS);
      localparam int              WOFF = w % PAGE_BYTES;
      logic [DATA_W-1:0] cell_q;
      logic              hit;

      assign hit = commit && (commit_page == WPG) && pbuf_vld[WOFF];

      if (RESET_ARRAY) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cell_q <= '0;
            else if (hit) cell_q <= pbuf_data[WOFF];
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (hit) cell_q <= pbuf_data[WOFF];
         end
      end

      assign words[w] = cell_q;
   end

   assign rd_data = words[rd_addr];
endmodule

// File: rtl/pgwr_status.sv
module pgwr_status #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              busy,
   input  logic              prog_start,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ADDR_W-1:0] last_addr,
   input  logic [DATA_W-1:0] last_data,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe
);
   localparam int POLL_BIT = DATA_W - 1;
   localparam int TOG_BIT  = DATA_W - 2;

   logic tgl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tgl_q <= 1'b0;
      else if (prog_start)       tgl_q <= 1'b0;
      else if (busy && rd_req)   tgl_q <= ~tgl_q;
   end

   always_comb begin
      rdata    = '0;
      rdata_oe = 1'b0;
      if (rd_req) begin
         rdata_oe = 1'b1;
         if (busy) begin
            if (rd_addr == last_addr) begin
               rdata           = last_data;
               rdata[POLL_BIT] = ~last_data[POLL_BIT];
            end
            rdata[TOG_BIT] = tgl_q;
         end else begin
            rdata = arr_data;
         end
      end
   end

   // R6
   tog_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && busy) |=> (!(rd_req && busy) || (rdata[TOG_BIT] != $past(rdata[TOG_BIT]))));

   // R1
   oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> (rdata == '0));
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int PAGE_BITS   = 8,
   parameter int LOAD_WIN    = 5000,
   parameter int PROG_CYC    = 500000,
   parameter bit RESET_ARRAY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   output logic              busy,
   output logic              page_err
);
   localparam int PG_W       = ADDR_W - PAGE_BITS;
   localparam int PAGE_BYTES = 1 << PAGE_BITS;

   initial begin
      assert (PAGE_BITS >= 1 && PAGE_BITS < ADDR_W)
         else $error("pgwr_ctrl: PAGE_BITS must lie in 1..ADDR_W-1");
      assert (DATA_W >= 2)
         else $error("pgwr_ctrl: DATA_W must hold both status bits");
      assert (LOAD_WIN >= 2)
         else $error("pgwr_ctrl: LOAD_WIN must be at least 2");
      assert (PROG_CYC >= 2)
         else $error("pgwr_ctrl: PROG_CYC must be at least 2");
   end

   logic                             wr_req, rd_req;
   logic                             ld_en, commit, prog_start;
   logic [PG_W-1:0]                  page_q;
   logic [ADDR_W-1:0]                last_addr;
   logic [DATA_W-1:0]                last_data;
   logic [PAGE_BYTES-1:0][DATA_W-1:0] pbuf_data;
   logic [PAGE_BYTES-1:0]            pbuf_vld;
   logic [DATA_W-1:0]                arr_data;

   assign wr_req = sel && wr_en && !rd_en;
   assign rd_req = sel && rd_en;

   pgwr_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
      .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .addr(addr), .wdata(wdata),
      .ld_en(ld_en), .busy(busy), .commit(commit), .prog_start(prog_start),
      .page_q(page_q), .last_addr(last_addr), .last_data(last_data),
      .page_err(page_err)
   );

   pgwr_pagebuf #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_pbuf (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_off(addr[PAGE_BITS-1:0]),
      .ld_data(wdata), .clear(commit), .pbuf_data(pbuf_data), .pbuf_vld(pbuf_vld)
   );

   pgwr_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
      .RESET_ARRAY(RESET_ARRAY)
   ) u_arr (
      .clk(clk), .rst_n(rst_n), .commit(commit), .commit_page(page_q),
      .pbuf_data(pbuf_data), .pbuf_vld(pbuf_vld), .rd_addr(addr),
      .rd_data(arr_data)
   );

   pgwr_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .busy(busy),
      .prog_start(prog_start), .rd_addr(addr), .last_addr(last_addr),
      .last_data(last_data), .arr_data(arr_data), .rdata(rdata),
      .rdata_oe(rdata_oe)
   );
endmodule

// File: tb/sim_pgwr_ctrl.sv
module sim_pgwr_ctrl;
   localparam int CLK_PER = 10;
   localparam int AW = 10;
   localparam int DW = 8;
   localparam int PB = 8;
   localparam int LW = 8;
   localparam int PC = 40;

   localparam logic [3:0] K_WR = 4'd1, K_RD = 4'd2, K_WB = 4'd3, K_WI = 4'd4;

   function automatic logic [35:0] vv(input logic [3:0] k, input logic [3:0] r,
                                      input logic [11:0] a, input logic [7:0] d,
                                      input logic [7:0] e);
      return {k, r, a, d, e};
   endfunction

   localparam int NV = 32;
   localparam logic [35:0] VEC [NV] = '{
      vv(K_WR, 4'd2,  12'h105, 8'h3C, 8'h00),  // R2 scattered loads
      vv(K_WR, 4'd2,  12'h1FF, 8'h81, 8'h00),
      vv(K_WR, 4'd2,  12'h100, 8'h7E, 8'h00),
      vv(K_RD, 4'd12, 12'h105, 8'h00, 8'h00),  // R12 pending byte invisible
      vv(K_WB, 4'd3,  12'h000, 8'h00, 8'h00),
      vv(K_RD, 4'd5,  12'h100, 8'h00, 8'hBE),  // R5 inverted top bit
      vv(K_RD, 4'd6,  12'h100, 8'h00, 8'hFE),  // R6 bit 6 flips
      vv(K_RD, 4'd11, 12'h005, 8'h00, 8'h00),  // R11 other address
      vv(K_RD, 4'd6,  12'h100, 8'h00, 8'hFE),
      vv(K_WR, 4'd7,  12'h200, 8'h55, 8'h00),  // R7 ignored while busy
      vv(K_WI, 4'd7,  12'h000, 8'h00, 8'h00),
      vv(K_RD, 4'd8,  12'h100, 8'h00, 8'h7E),  // R8 true data
      vv(K_RD, 4'd8,  12'h105, 8'h00, 8'h3C),
      vv(K_RD, 4'd8,  12'h1FF, 8'h00, 8'h81),
      vv(K_RD, 4'd9,  12'h101, 8'h00, 8'h00),  // R9 not loaded
      vv(K_RD, 4'd7,  12'h200, 8'h00, 8'h00),
      vv(K_WR, 4'd2,  12'h101, 8'hA5, 8'h00),  // R2 single-byte operation
      vv(K_WB, 4'd3,  12'h000, 8'h00, 8'h00),
      vv(K_RD, 4'd5,  12'h101, 8'h00, 8'h25),
      vv(K_RD, 4'd11, 12'h105, 8'h00, 8'h40),
      vv(K_WI, 4'd7,  12'h000, 8'h00, 8'h00),
      vv(K_RD, 4'd9,  12'h105, 8'h00, 8'h3C),  // R9 old byte kept
      vv(K_RD, 4'd8,  12'h101, 8'h00, 8'hA5),
      vv(K_WR, 4'd4,  12'h300, 8'h11, 8'h00),  // R4 wrong page follows
      vv(K_WR, 4'd4,  12'h000, 8'h22, 8'h01),
      vv(K_WR, 4'd4,  12'h301, 8'hC3, 8'h00),
      vv(K_WB, 4'd3,  12'h000, 8'h00, 8'h00),
      vv(K_RD, 4'd5,  12'h301, 8'h00, 8'h03),
      vv(K_WI, 4'd7,  12'h000, 8'h00, 8'h00),
      vv(K_RD, 4'd8,  12'h300, 8'h00, 8'h11),
      vv(K_RD, 4'd4,  12'h000, 8'h00, 8'h00),
      vv(K_RD, 4'd8,  12'h301, 8'h00, 8'hC3)
   };

   logic          clk, rst_n, sel, rd_en, wr_en;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata, rdata;
   logic          rdata_oe, busy, page_err;
   int            n_chk = 0, n_err = 0;
   bit            done = 1'b0;

   pgwr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB), .LOAD_WIN(LW),
               .PROG_CYC(PC), .RESET_ARRAY(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
      .busy(busy), .page_err(page_err));

   initial clk = 1'b0;
   always #(CLK_PER/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      sel = 1'b1; wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic [AW-1:0] a, output logic [DW-1:0] v, output logic o);
      sel = 1'b1; rd_en = 1'b1; wr_en = 1'b0; addr = a;
      #1;
      v = rdata; o = rdata_oe;
      @(negedge clk);
      sel = 1'b0; rd_en = 1'b0;
   endtask

   task automatic wait_busy(input logic lvl, input string req);
      int n = 0;
      while (busy !== lvl && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(busy === lvl, req, busy, lvl);
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] e, input string req);
      logic [DW-1:0] v;
      logic o;
      do_rd(a, v, o);
      chk(o === 1'b1 && v === e, req, {o, v}, {1'b1, e});
   endtask

   initial begin
      #(CLK_PER * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      logic          o;
      int            n, m;
      rst_n = 1'b0; sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk(busy === 1'b0 && page_err === 1'b0 && rdata_oe === 1'b0 && rdata === '0,
          "R10 reset outputs", {busy, page_err, rdata_oe}, 0);

      for (int i = 0; i < NV; i++) begin
         logic [3:0]    k, r;
         logic [AW-1:0] a;
         logic [DW-1:0] d, e;
         string         tag;
         k = VEC[i][35:32]; r = VEC[i][31:28]; a = AW'(VEC[i][27:16]);
         d = VEC[i][15:8];  e = VEC[i][7:0];
         tag = $sformatf("R%0d vector %0d", r, i);
         case (k)
            K_WR: begin
               do_wr(a, d);
               chk(page_err === e[0], tag, page_err, e[0]);
            end
            K_RD: rd_chk(a, e, tag);
            K_WB: wait_busy(1'b1, tag);
            default: wait_busy(1'b0, tag);
         endcase
      end

      // R3: load exactly at window limit accepted, then busy after LW edges
      do_wr(10'h010, 8'h01);
      repeat (LW - 1) @(negedge clk);
      do_wr(10'h011, 8'h02);
      chk(busy === 1'b0, "R3 window edge load keeps idle", busy, 0);
      n = 0;
      while (busy !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
      chk(n == LW, "R3 busy rise delay", n, LW);
      // R7 busy length
      m = 0;
      while (busy === 1'b1 && m < 1000) begin m++; @(negedge clk); end
      chk(m == PC, "R7 busy length", m, PC);
      rd_chk(10'h010, 8'h01, "R3 first byte kept");
      rd_chk(10'h011, 8'h02, "R3 edge byte committed");

      // R3 late load: window already closed
      do_wr(10'h020, 8'h0F);
      repeat (LW) @(negedge clk);
      chk(busy === 1'b1, "R3 late load finds busy", busy, 1);
      do_wr(10'h021, 8'hF0);
      chk(page_err === 1'b0, "R7 no flag while busy", page_err, 0);
      wait_busy(1'b0, "R7 end of late programming");
      rd_chk(10'h021, 8'h00, "R7 late load ignored");
      rd_chk(10'h020, 8'h0F, "R8 early byte stored");

      // R2 full page of 256 loads
      for (int b = 0; b < 256; b++) do_wr(AW'(10'h200 + b), DW'(b) ^ 8'h5A);
      wait_busy(1'b1, "R2 full page programming");
      wait_busy(1'b0, "R2 full page done");
      rd_chk(10'h200, 8'h5A, "R2 page byte 0");
      rd_chk(10'h2FF, 8'hA5, "R2 page byte 255");
      rd_chk(10'h280, 8'hDA, "R2 page byte 128");

      // R1 qualifiers
      sel = 1'b1; wr_en = 1'b1; rd_en = 1'b1; addr = 10'h3FE; wdata = 8'h77;
      #1;
      chk(rdata_oe === 1'b1 && rdata === 8'h00, "R1 read wins over write", {rdata_oe, rdata}, 9'h100);
      @(negedge clk);
      sel = 1'b0; wr_en = 1'b1; rd_en = 1'b1;
      #1;
      chk(rdata_oe === 1'b0 && rdata === 8'h00, "R1 no select no output", {rdata_oe, rdata}, 0);
      rd_en = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (LW + 2) @(negedge clk);
      chk(busy === 1'b0, "R1 no load taken", busy, 0);
      rd_chk(10'h3FE, 8'h00, "R1 location unchanged");
      rd_chk(10'h3FF, 8'h00, "R10 untouched location zero");

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule